// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block connects a single-request internal port to one external asynchronous 16-bit static RAM. Each accepted request becomes one complete memory cycle on the pins. A read drives the address, both chip enables and output enable, waits a set number of clock cycles for the access time, then registers the returned word. The word comes back with a one-cycle valid strobe. A write drops write enable, waits until the memory has released the data bus, drives the write data for the programmed pulse width, and raises write enable while the chip stays selected. A byte mask chooses which 8-bit lanes a cycle touches.

Access time, write pulse width and bus turnaround are parameters counted in clock cycles. The controller tracks how long output enable has been inactive. A write that follows a read therefore waits out the turnaround, and a write that arrives on a quiet bus drives data at once. While a cycle is in progress the port is not ready, and any request presented during that time is dropped.

Top module: `sram_port_ctrl`

## Requirements
- R1: Out of reset the port is ready, and the pins are idle. Idle means: active-low chip enable high, active-high chip enable low, write enable high, output enable high, both byte enables high, data bus not driven and no read valid.
- R2: During a read, both chip enables are active, write enable is high and output enable is low. The address stays stable while output enable is low. Output enable is low for T_ACC+2 cycles, and the data is sampled at the end of the last of them.
- R3: Read data appears on rsp_rdata with rsp_valid high for exactly one cycle. A lane whose mask bit is 0 reads as zero. Mask bit 1 selects bits 15:8 and mask bit 0 selects bits 7:0.
- R4: During a cycle, the upper byte enable (active low) equals the inverse of mask bit 1 and the lower byte enable equals the inverse of mask bit 0. With mask 00 no byte of the memory changes.
- R5: During a write, write enable is low only while both chip enables are active and output enable is high. The data bus is driven for exactly T_WP cycles while write enable is low. Write enable then rises while the chip enables are still active and the data is still driven.
- R6: The data bus is never driven until output enable has been high for at least T_TURN full cycles. A write accepted on a quiet bus drives data in the first cycle after acceptance. A write right after a read (T_TURN=2) waits one cycle with the bus undriven.
- R7: req_ready is low from the cycle after acceptance until the cycle finishes. A request presented while req_ready is low is not performed.
- R8: Data written to an address reads back unchanged, and lanes not written keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane select, bit 1 = upper byte, bit 0 = lower byte |
| req_ready | output | 1 | Controller idle, request accepted at this edge |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_ce | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| dq_out | output | 16 | Data to drive on the bus |
| dq_oe | output | 1 | Bus driver enable |
| dq_in | input | 16 | Data sampled from the bus |

## Verification
The bench models the memory so that it returns a poison word until the access window has passed, and it fills unselected lanes with a filler byte. A read sampled too early, or a lane that is not masked, therefore shows up as a data mismatch. Writes are issued with full, upper-only, lower-only and empty masks, and each is read back with several masks, which separates the lane-enable decoding from the read masking. A write after a read and a write after an idle stretch show whether the turnaround wait depends on recent output-enable activity. A request pulsed while busy, to an address later read back, shows that requests are gated by ready.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPT,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_RECOV
  } ctl_state_t;

  // Reload value of the dwell counter on entry to a state (cycles minus one).
  function automatic int unsigned dwell_load(ctl_state_t s, int unsigned t_acc,
                                             int unsigned t_wp);
    case (s)
      ST_RD_WAIT:  return t_acc - 1;
      ST_WR_PULSE: return t_wp - 1;
      default:     return 0;
    endcase
  endfunction

  // True when the current output-enable-high cycle completes the turnaround.
  function automatic logic turn_elapsed(int unsigned quiet, int unsigned t_turn);
    return (quiet + 1) >= t_turn;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_ctl_busguard.sv
module sram_ctl_busguard
  import sram_ctl_pkg::*;
#(
  parameter int T_TURN = 2,
  parameter int Q_W    = $clog2(T_TURN + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           oe_on,
  output logic [Q_W-1:0] quiet,
  output logic           turn_ok
);
  localparam logic [Q_W-1:0] QMAX = Q_W'(T_TURN);

  // quiet = completed cycles with output enable inactive, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              quiet <= QMAX;
    else if (oe_on)          quiet <= '0;
    else if (quiet < QMAX)   quiet <= quiet + 1'b1;
  end

  assign turn_ok = !oe_on && turn_elapsed(32'(quiet), T_TURN);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int T_ACC = 3,
  parameter int T_WP  = 2,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic turn_ok,
  output logic ready,
  output logic accept,
  output logic ce_on,
  output logic we_on,
  output logic oe_on,
  output logic drive,
  output logic cap_en
);
  ctl_state_t st, nxt;
  logic       expired;
  logic       t_load;
  logic [CNT_W-1:0] t_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:
        if (req_valid)
          nxt = !req_write ? ST_RD_SETUP : (turn_ok ? ST_WR_PULSE : ST_WR_TURN);
      ST_RD_SETUP: nxt = ST_RD_WAIT;
      ST_RD_WAIT:  if (expired) nxt = ST_RD_CAPT;
      ST_RD_CAPT:  nxt = ST_IDLE;
      ST_WR_TURN:  if (turn_ok) nxt = ST_WR_PULSE;
      ST_WR_PULSE: if (expired) nxt = ST_WR_RECOV;
      ST_WR_RECOV: nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign t_load = (nxt != st);
  assign t_val  = CNT_W'(dwell_load(nxt, T_ACC, T_WP));

  sram_ctl_timer #(.CNT_W(CNT_W)) i_dwell (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(expired)
  );

  assign ready  = (st == ST_IDLE);
  assign accept = ready && req_valid;
  assign ce_on  = (st != ST_IDLE);
  assign oe_on  = (st == ST_RD_SETUP) || (st == ST_RD_WAIT) || (st == ST_RD_CAPT);
  assign we_on  = (st == ST_WR_TURN) || (st == ST_WR_PULSE);
  assign drive  = (st == ST_WR_PULSE) || (st == ST_WR_RECOV);
  assign cap_en = (st == ST_RD_CAPT);

  // R2
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD_SETUP) |=> (st == ST_RD_WAIT));

  // R5
  pulse_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_PULSE && !expired) |=> (st == ST_WR_PULSE));
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int NL = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NL-1:0] req_bmask,
  input  logic          lane_on,
  input  logic          cap_en,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] wdata,
  output logic [NL-1:0] lane_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [NL-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wdata    <= '0;
      mask_q   <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      wdata    <= req_wdata;
      mask_q   <= req_bmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= cap_en;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane_n[g] = !(lane_on && mask_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata[g*8 +: 8] <= '0;
      else if (cap_en) rdata[g*8 +: 8] <= mask_q[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl #(
  parameter int AW     = 18,
  parameter int DW     = 16,
  parameter int T_ACC  = 3,
  parameter int T_WP   = 2,
  parameter int T_TURN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_bmask,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ce,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          sram_ub_n,
  output logic          sram_lb_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  localparam int MAXD  = (T_ACC > T_WP) ? T_ACC : T_WP;
  localparam int CNT_W = $clog2(MAXD + 1) + 1;
  localparam int Q_W   = $clog2(T_TURN + 2);

  logic accept, ce_on, we_on, oe_on, drive, cap_en, turn_ok;
  logic [Q_W-1:0] quiet;
  logic [1:0]     lane_n;

  sram_ctl_fsm #(.T_ACC(T_ACC), .T_WP(T_WP), .CNT_W(CNT_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .turn_ok(turn_ok), .ready(req_ready), .accept(accept), .ce_on(ce_on),
    .we_on(we_on), .oe_on(oe_on), .drive(drive), .cap_en(cap_en)
  );

  sram_ctl_busguard #(.T_TURN(T_TURN), .Q_W(Q_W)) i_guard (
    .clk(clk), .rst_n(rst_n), .oe_on(oe_on), .quiet(quiet), .turn_ok(turn_ok)
  );

  sram_ctl_lanes #(.AW(AW), .DW(DW), .NL(2)) i_lanes (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_bmask(req_bmask), .lane_on(ce_on),
    .cap_en(cap_en), .dq_in(dq_in), .mem_addr(sram_addr), .wdata(dq_out),
    .lane_n(lane_n), .rdata(rsp_rdata), .rvalid(rsp_valid)
  );

  assign sram_ce_n = !ce_on;
  assign sram_ce   = ce_on;
  assign sram_we_n = !we_on;
  assign sram_oe_n = !oe_on;
  assign sram_ub_n = lane_n[1];
  assign sram_lb_n = lane_n[0];
  assign dq_oe     = drive;

  // R5
  we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_ce && sram_oe_n));

  // R5
  we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (dq_oe && !sram_ce_n));

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (sram_oe_n && (32'(quiet) >= T_TURN)));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/test_sram_port_ctrl.sv
module test_sram_port_ctrl;
  localparam int T_ACC  = 3;
  localparam int T_WP   = 2;
  localparam int T_TURN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
  logic [15:0] dq_out, dq_in;
  logic        dq_oe;

  always #10 clk = ~clk;

  sram_port_ctrl #(.T_ACC(T_ACC), .T_WP(T_WP), .T_TURN(T_TURN)) i_sram_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n),
    .sram_lb_n(sram_lb_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---- memory model: poison until access window elapsed ----
  logic [15:0] sim_mem [0:63];
  logic [15:0] ref_mem [0:63];
  int rd_run = 0;
  logic read_cond;
  assign read_cond = !sram_ce_n && sram_ce && sram_we_n && !sram_oe_n;

  always @(posedge clk) rd_run <= read_cond ? rd_run + 1 : 0;

  always_comb begin
    if (read_cond && rd_run >= T_ACC + 1)
      dq_in = {sram_ub_n ? 8'hEE : sim_mem[sram_addr[5:0]][15:8],
               sram_lb_n ? 8'hEE : sim_mem[sram_addr[5:0]][7:0]};
    else
      dq_in = 16'hBAD0;
  end

  // ---- write monitor ----
  logic [17:0] exp_waddr = '0;
  logic [1:0]  exp_wmask = '0;
  int  pw = 0, quiet_b = 100;
  bit  we_was_low = 1'b0, clash = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (sram_oe_n) quiet_b++; else quiet_b = 0;
    if (dq_oe && (quiet_b - 1) < T_TURN) clash = 1'b1;
    if (!sram_we_n) begin
      if (dq_oe) pw++;
    end else if (we_was_low) begin
      chk(pw == T_WP, "R5", pw, T_WP, "write pulse width");
      chk(dq_oe && !sram_ce_n && sram_ce, "R5", {dq_oe, sram_ce_n, sram_ce}, 3'b101,
          "we rise with chip selected and data driven");
      chk({sram_ub_n, sram_lb_n} == ~exp_wmask, "R4", {sram_ub_n, sram_lb_n}, ~exp_wmask,
          "byte enables during write");
      chk(sram_addr == exp_waddr, "R5", sram_addr, exp_waddr, "write address");
      chk(!clash, "R6", clash, 0, "bus driven before turnaround elapsed");
      if (!sram_ub_n) sim_mem[sram_addr[5:0]][15:8] = dq_out[15:8];
      if (!sram_lb_n) sim_mem[sram_addr[5:0]][7:0]  = dq_out[7:0];
      pw = 0;
      clash = 1'b0;
    end
    we_was_low = !sram_we_n;
  end

  // ---- scoreboard ----
  logic [15:0] exp_q [$];

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) chk(1'b0, "R3", rsp_rdata, 0, "unexpected read valid");
    else begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk(rsp_rdata == e, "R8", rsp_rdata, e, "read data (R3 masking)");
    end
  end

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, input int direct);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    if (wr) begin
      exp_waddr = a; exp_wmask = m;
      if (m[1]) ref_mem[a[5:0]][15:8] = d[15:8];
      if (m[0]) ref_mem[a[5:0]][7:0]  = d[7:0];
    end else
      exp_q.push_back({m[1] ? ref_mem[a[5:0]][15:8] : 8'h00,
                       m[0] ? ref_mem[a[5:0]][7:0]  : 8'h00});
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7", req_ready, 0, "ready low after acceptance");
    if (wr && direct >= 0)
      chk(dq_oe == direct[0], "R6", dq_oe, direct, "data drive in first cycle after accept");
    if (!wr) begin
      chk(read_cond, "R2", {sram_ce_n, sram_ce, sram_we_n, sram_oe_n}, 4'b0110, "read pins");
      chk({sram_ub_n, sram_lb_n} == ~m, "R4", {sram_ub_n, sram_lb_n}, ~m,
          "byte enables during read");
    end
  endtask

  task automatic drain();
    int k = 0;
    while ((!req_ready || exp_q.size() != 0) && k < 200) begin
      @(negedge clk); k++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", 0, 1, "watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin sim_mem[i] = 16'h0; ref_mem[i] = 16'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state
    chk(req_ready && sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && sram_ub_n &&
        sram_lb_n && !dq_oe && !rsp_valid, "R1",
        {req_ready, sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, dq_oe, rsp_valid},
        9'b110111100, "idle pins after reset");

    do_req(1, 18'h00005, 16'h1234, 2'b11, 1);   // quiet bus: direct drive (R6)
    do_req(0, 18'h00005, 16'h0, 2'b11, -1);
    do_req(1, 18'h00005, 16'hAB99, 2'b10, 0);   // right after read: turnaround (R6)
    do_req(0, 18'h00005, 16'h0, 2'b11, -1);     // R8 upper only changed
    drain();
    do_req(1, 18'h00005, 16'h77CD, 2'b01, 1);
    do_req(0, 18'h00005, 16'h0, 2'b01, -1);     // R3 upper lane zero
    do_req(0, 18'h00005, 16'h0, 2'b10, -1);     // R3 lower lane zero
    do_req(1, 18'h00005, 16'hFFFF, 2'b00, 0);   // R4 no lane written
    do_req(0, 18'h00005, 16'h0, 2'b11, -1);
    drain();

    // R7: request presented while busy is dropped
    do_req(1, 18'h00009, 16'h5555, 2'b11, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00009; req_wdata = 16'h9999;
    req_bmask = 2'b11;
    chk(!req_ready, "R7", req_ready, 0, "busy while second request presented");
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    do_req(0, 18'h00009, 16'h0, 2'b11, -1);

    // R8 address extremes, back-to-back reads
    do_req(1, 18'h3FFFF, 16'hC3A5, 2'b11, 0);
    do_req(1, 18'h00000, 16'h0F0F, 2'b11, 1);
    do_req(0, 18'h3FFFF, 16'h0, 2'b11, -1);
    do_req(0, 18'h00000, 16'h0, 2'b11, -1);
    do_req(0, 18'h00009, 16'h0, 2'b11, -1);
    drain();

    chk(exp_q.size() == 0, "R3", exp_q.size(), 0, "all reads answered");
    chk(req_ready && sram_ce_n && !dq_oe, "R1", {req_ready, sram_ce_n, dq_oe}, 3'b110,
        "idle again at end");
    done = 1'b1;
    report();
  end
endmodule